// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Unit

This block sits between instruction decode and three execution queues. It holds a four-entry pre-issue queue and a table with one pending-write bit per architectural register. Each cycle it looks at the queue as it stood at the end of the previous cycle. It sends up to three instructions, in any order, to three functional-unit queues. Memory operations go to unit 0, arithmetic operations to unit 1 and logical operations to unit 2. Each unit takes at most one instruction per cycle.

An entry may leave the queue only when all of these hold: its source registers carry no pending write, no older queued entry will write them, its own write cannot overtake an older read or write of the same register, and its unit queue is not full. An issued instruction marks its destination as pending. The writeback ports clear that mark at the end of their cycle. The entries that stay behind move up toward slot 0 without changing their order. Newly decoded instructions are appended behind them and take part in selection from the following cycle.

Top module: `ooo_issue_unit`

## Requirements
- R1: After reset the queue is empty, no register is pending and no issue strobe is high.
- R2: Class code 0 (memory) issues only on unit 0, code 1 (arithmetic) only on unit 1 and code 2 (logical) only on unit 2. At most one instruction issues per unit per cycle, so at most three issue in total.
- R3: When several ready entries share a class, the one nearest slot 0 issues and the rest wait. An entry that cannot issue does not stop a younger entry of another class, or of the same class, from issuing.
- R4: No instruction issues to a unit whose full flag is high in that cycle.
- R5: An entry whose source register is pending at the end of the previous cycle does not issue. This holds even when that register is being written back in the current cycle.
- R6: An entry does not issue while one of its source registers is the destination of an older entry that was in the queue at the start of the cycle.
- R7: An entry does not issue while its destination is pending, is the destination of an older queued entry, or is a source of an older queued entry.
- R8: Issuing an instruction makes its destination pending from the next cycle. A writeback strobe makes its register not pending from the next cycle. busy_regs shows the pending bits.
- R9: Register 0 is never pending and never blocks an instruction.
- R10: Entries that do not issue move toward slot 0 in their original order, with accepted new entries behind them. An entry appended in a cycle is not considered until the next cycle.
- R11: Enqueue lanes are taken in lane order, but only up to the number of free slots at the end of the previous cycle. Lanes beyond that are dropped.
- R12: Each issue port carries the destination and both source fields of the chosen entry. q_remove marks the queue slots that issued in the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_vld | input | ENQ_W | Per-lane enqueue strobe |
| enq_cls | input | 2*ENQ_W | Per-lane class code (0 mem, 1 arith, 2 logic) |
| enq_dst | input | RW*ENQ_W | Per-lane destination register |
| enq_src1 | input | RW*ENQ_W | Per-lane first source register |
| enq_src2 | input | RW*ENQ_W | Per-lane second source register |
| fu_full | input | 3 | Full flag of each unit queue |
| wb_vld | input | WB_PORTS | Writeback strobe per port |
| wb_reg | input | RW*WB_PORTS | Register written back per port |
| iss_vld | output | 3 | Issue strobe per unit |
| iss_dst | output | 3*RW | Destination of the issued instruction per unit |
| iss_src1 | output | 3*RW | First source per unit |
| iss_src2 | output | 3*RW | Second source per unit |
| q_remove | output | QDEPTH | Queue slots that issued this cycle |
| q_count | output | CW | Occupied queue slots |
| busy_regs | output | NREG | Pending-write bit per register |

## Verification
The hardest case to reach is a cycle in which an entry is held back only by an older entry that issues in that same cycle. The older entry is no longer in the queue one cycle later, so the hazard lasts for exactly one cycle and is easy to miss. Directed sequences set this up on purpose. They place a producer and its reader in the same enqueue beat, and a reader behind a writer of the register it reads. They also combine a full unit with a refused fill, and clear a register on the same cycle that a reader waits on it. A long random run then follows on a register pool of only eight registers, so that overlaps happen all the time. A behavioural model decides every issue in the bench.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  parameter int unsigned SB_NREG = 32;
  localparam int unsigned SB_RW  = $clog2(SB_NREG);
  localparam int unsigned SB_NFU = 3;

  typedef logic [SB_RW-1:0] reg_idx_t;

  typedef enum logic [1:0] {
    CL_MEM   = 2'd0,
    CL_ARITH = 2'd1,
    CL_LOGIC = 2'd2,
    CL_RSVD  = 2'd3
  } op_class_e;

  typedef struct packed {
    op_class_e cls;
    reg_idx_t  dst;
    reg_idx_t  src1;
    reg_idx_t  src2;
  } iq_entry_t;

  // register 0 is hardwired and never tracked
  function automatic logic reg_named(reg_idx_t r);
    return r != '0;
  endfunction

  function automatic logic reg_busy(logic [SB_NREG-1:0] busy, reg_idx_t r);
    return reg_named(r) && busy[r];
  endfunction

  // true when a names a tracked register that equals b
  function automatic logic reg_clash(reg_idx_t a, reg_idx_t b);
    return reg_named(a) && (a == b);
  endfunction

  function automatic logic [SB_NREG-1:0] reg_onehot(reg_idx_t r);
    logic [SB_NREG-1:0] m;
    m = '0;
    if (reg_named(r)) m[r] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sbi_queue.sv
module sbi_queue
  import sbi_pkg::*;
#(
  parameter int unsigned QDEPTH = 4,
  parameter int unsigned ENQ_W  = 2,
  localparam int unsigned CW    = $clog2(QDEPTH + 1),
  localparam int unsigned IW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QDEPTH-1:0] rm_mask,
  input  logic [ENQ_W-1:0]  enq_vld,
  input  iq_entry_t         enq_ent [ENQ_W],
  output iq_entry_t         ent     [QDEPTH],
  output logic [QDEPTH-1:0] ent_vld,
  output logic [CW-1:0]     count
);
  localparam logic [CW-1:0] DEPTH_C = CW'(QDEPTH);

  iq_entry_t       ent_q [QDEPTH];
  iq_entry_t       ent_d [QDEPTH];
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [CW-1:0]   free_slots, taken;

  genvar gi;
  generate
    for (gi = 0; gi < QDEPTH; gi++) begin : g_vld
      assign ent_vld[gi] = cnt_q > CW'(gi);
      assign ent[gi]     = ent_q[gi];
    end
  endgenerate

  // survivors slide toward slot 0, then accepted lanes go behind them
  always_comb begin
    free_slots = DEPTH_C - cnt_q;
    for (int i = 0; i < QDEPTH; i++) ent_d[i] = ent_q[i];
    cnt_d = '0;
    taken = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (ent_vld[i] && !rm_mask[i]) begin
        ent_d[cnt_d[IW-1:0]] = ent_q[i];
        cnt_d = cnt_d + CW'(1);
      end
    end
    for (int l = 0; l < ENQ_W; l++) begin
      if (enq_vld[l] && (taken < free_slots)) begin
        ent_d[cnt_d[IW-1:0]] = enq_ent[l];
        cnt_d = cnt_d + CW'(1);
        taken = taken + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < QDEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < QDEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign count = cnt_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C); // R11
  AST_REMOVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_mask & ~ent_vld) == '0); // R12
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == DEPTH_C) && (rm_mask == '0) |=> cnt_q == DEPTH_C); // R11
endmodule

// File: rtl/sbi_scoreboard.sv
module sbi_scoreboard
  import sbi_pkg::*;
#(
  parameter int unsigned WB_PORTS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SB_NFU-1:0]   set_vld,
  input  reg_idx_t            set_reg [SB_NFU],
  input  logic [WB_PORTS-1:0] wb_vld,
  input  reg_idx_t            wb_reg  [WB_PORTS],
  output logic [SB_NREG-1:0]  busy
);
  logic [SB_NREG-1:0] busy_q, set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int f = 0; f < SB_NFU; f++)
      if (set_vld[f]) set_mask = set_mask | reg_onehot(set_reg[f]);
    for (int p = 0; p < WB_PORTS; p++)
      if (wb_vld[p]) clr_mask = clr_mask | reg_onehot(wb_reg[p]);
  end

  // clears and sets land together at the end of the cycle
  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~clr_mask) | set_mask;
  end

  assign busy = busy_q;

  AST_X0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q[0]); // R9

  genvar gf, gp;
  generate
    for (gf = 0; gf < SB_NFU; gf++) begin : g_set
      AST_SET_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld[gf] |-> !reg_busy(busy_q, set_reg[gf])); // R7
      AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld[gf] && reg_named(set_reg[gf]) |=> busy_q[$past(set_reg[gf])]); // R8
    end
    for (gp = 0; gp < WB_PORTS; gp++) begin : g_clr
      AST_WB_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld[gp] && reg_named(wb_reg[gp]) |-> busy_q[wb_reg[gp]]); // R8
      AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld[gp] && reg_named(wb_reg[gp]) |=> !busy_q[$past(wb_reg[gp])]); // R8
    end
  endgenerate
endmodule

// File: rtl/sbi_pick.sv
module sbi_pick
  import sbi_pkg::*;
#(
  parameter int unsigned QDEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  iq_entry_t          ent     [QDEPTH],
  input  logic [QDEPTH-1:0]  ent_vld,
  input  logic [SB_NREG-1:0] busy,
  input  logic [SB_NFU-1:0]  fu_full,
  output logic [SB_NFU-1:0]  iss_vld,
  output iq_entry_t          iss_ent [SB_NFU],
  output logic [QDEPTH-1:0]  rm_mask
);
  // per-entry hazard reasons, visible for assertions and debug
  logic [QDEPTH-1:0] raw_ahead, war_ahead, waw_ahead;
  logic [QDEPTH-1:0] src_wait, dst_wait, ent_ready;
  logic [SB_NFU-1:0] fu_taken;

  genvar gi;
  generate
    for (gi = 0; gi < QDEPTH; gi++) begin : g_haz
      logic raw_l, war_l, waw_l;
      always_comb begin
        raw_l = 1'b0;
        war_l = 1'b0;
        waw_l = 1'b0;
        for (int j = 0; j < gi; j++) begin
          if (ent_vld[j]) begin
            raw_l = raw_l | reg_clash(ent[j].dst, ent[gi].src1)
                          | reg_clash(ent[j].dst, ent[gi].src2);
            war_l = war_l | reg_clash(ent[gi].dst, ent[j].src1)
                          | reg_clash(ent[gi].dst, ent[j].src2);
            waw_l = waw_l | reg_clash(ent[gi].dst, ent[j].dst);
          end
        end
      end
      assign raw_ahead[gi] = raw_l;
      assign war_ahead[gi] = war_l;
      assign waw_ahead[gi] = waw_l;
      assign src_wait[gi]  = reg_busy(busy, ent[gi].src1) | reg_busy(busy, ent[gi].src2);
      assign dst_wait[gi]  = reg_busy(busy, ent[gi].dst);
      assign ent_ready[gi] = ent_vld[gi] && (ent[gi].cls != CL_RSVD)
                          && !src_wait[gi] && !dst_wait[gi]
                          && !raw_ahead[gi] && !war_ahead[gi] && !waw_ahead[gi];
    end
  endgenerate

  // oldest-first scan; a full unit counts as already taken
  always_comb begin
    fu_taken = fu_full;
    iss_vld  = '0;
    rm_mask  = '0;
    for (int f = 0; f < SB_NFU; f++) iss_ent[f] = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      for (int f = 0; f < SB_NFU; f++) begin
        if (ent_ready[i] && (int'(ent[i].cls) == f) && !fu_taken[f]) begin
          fu_taken[f] = 1'b1;
          iss_vld[f]  = 1'b1;
          iss_ent[f]  = ent[i];
          rm_mask[i]  = 1'b1;
        end
      end
    end
  end

  AST_ISSUE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rm_mask) == $countones(iss_vld)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld & fu_full) == '0); // R4
  AST_NO_RAW_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_mask & raw_ahead) == '0); // R6
  AST_NO_ORDER_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_mask & (war_ahead | waw_ahead)) == '0); // R7

  genvar gf;
  generate
    for (gf = 0; gf < SB_NFU; gf++) begin : g_chk
      AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[gf] |-> !reg_busy(busy, iss_ent[gf].src1)
                     && !reg_busy(busy, iss_ent[gf].src2)); // R5
    end
  endgenerate
endmodule

// File: rtl/ooo_issue_unit.sv
module ooo_issue_unit
  import sbi_pkg::*;
#(
  parameter int unsigned QDEPTH   = 4,
  parameter int unsigned ENQ_W    = 2,
  parameter int unsigned WB_PORTS = 3,
  localparam int unsigned RW      = SB_RW,
  localparam int unsigned CW      = $clog2(QDEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ENQ_W-1:0]       enq_vld,
  input  logic [2*ENQ_W-1:0]     enq_cls,
  input  logic [RW*ENQ_W-1:0]    enq_dst,
  input  logic [RW*ENQ_W-1:0]    enq_src1,
  input  logic [RW*ENQ_W-1:0]    enq_src2,
  input  logic [SB_NFU-1:0]      fu_full,
  input  logic [WB_PORTS-1:0]    wb_vld,
  input  logic [RW*WB_PORTS-1:0] wb_reg,
  output logic [SB_NFU-1:0]      iss_vld,
  output logic [RW*SB_NFU-1:0]   iss_dst,
  output logic [RW*SB_NFU-1:0]   iss_src1,
  output logic [RW*SB_NFU-1:0]   iss_src2,
  output logic [QDEPTH-1:0]      q_remove,
  output logic [CW-1:0]          q_count,
  output logic [SB_NREG-1:0]     busy_regs
);
  iq_entry_t          enq_ent [ENQ_W];
  iq_entry_t          q_ent   [QDEPTH];
  logic [QDEPTH-1:0]  q_vld;
  logic [QDEPTH-1:0]  rm_mask;
  iq_entry_t          pk_ent  [SB_NFU];
  logic [SB_NFU-1:0]  pk_vld;
  reg_idx_t           set_reg [SB_NFU];
  reg_idx_t           wb_idx  [WB_PORTS];
  logic [SB_NREG-1:0] busy;

  genvar gl, gf, gp;
  generate
    for (gl = 0; gl < ENQ_W; gl++) begin : g_lane
      assign enq_ent[gl] = '{cls:  op_class_e'(enq_cls[2*gl +: 2]),
                             dst:  enq_dst[RW*gl +: RW],
                             src1: enq_src1[RW*gl +: RW],
                             src2: enq_src2[RW*gl +: RW]};
    end
    for (gf = 0; gf < SB_NFU; gf++) begin : g_unit
      assign set_reg[gf]            = pk_ent[gf].dst;
      assign iss_dst[RW*gf +: RW]   = pk_ent[gf].dst;
      assign iss_src1[RW*gf +: RW]  = pk_ent[gf].src1;
      assign iss_src2[RW*gf +: RW]  = pk_ent[gf].src2;
      AST_ROUTE_BY_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        pk_vld[gf] |-> int'(pk_ent[gf].cls) == gf); // R2
      AST_DEST_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pk_vld[gf] && reg_named(pk_ent[gf].dst) |=> busy_regs[$past(pk_ent[gf].dst)]); // R8
    end
    for (gp = 0; gp < WB_PORTS; gp++) begin : g_wb
      assign wb_idx[gp] = wb_reg[RW*gp +: RW];
    end
  endgenerate

  sbi_queue #(.QDEPTH(QDEPTH), .ENQ_W(ENQ_W)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .rm_mask (rm_mask),
    .enq_vld (enq_vld),
    .enq_ent (enq_ent),
    .ent     (q_ent),
    .ent_vld (q_vld),
    .count   (q_count)
  );

  sbi_pick #(.QDEPTH(QDEPTH)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .ent     (q_ent),
    .ent_vld (q_vld),
    .busy    (busy),
    .fu_full (fu_full),
    .iss_vld (pk_vld),
    .iss_ent (pk_ent),
    .rm_mask (rm_mask)
  );

  sbi_scoreboard #(.WB_PORTS(WB_PORTS)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vld (pk_vld),
    .set_reg (set_reg),
    .wb_vld  (wb_vld),
    .wb_reg  (wb_idx),
    .busy    (busy)
  );

  assign iss_vld   = pk_vld;
  assign q_remove  = rm_mask;
  assign busy_regs = busy;

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == '0) |-> (iss_vld == '0)); // R10
  AST_AT_MOST_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_remove) <= SB_NFU); // R2
endmodule

// File: tb/ooo_issue_unit_tb_top.sv
module ooo_issue_unit_tb_top;
  import sbi_pkg::*;
  localparam int QD = 4;
  localparam int EW = 2;
  localparam int WP = 3;
  localparam int RW = SB_RW;
  localparam int NR = SB_NREG;
  localparam int CW = $clog2(QD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic [EW-1:0]    enq_vld = '0;
  logic [2*EW-1:0]  enq_cls = '0;
  logic [RW*EW-1:0] enq_dst = '0, enq_src1 = '0, enq_src2 = '0;
  logic [2:0]       fu_full = '0;
  logic [WP-1:0]    wb_vld = '0;
  logic [RW*WP-1:0] wb_reg = '0;
  logic [2:0]       iss_vld;
  logic [3*RW-1:0]  iss_dst, iss_src1, iss_src2;
  logic [QD-1:0]    q_remove;
  logic [CW-1:0]    q_count;
  logic [NR-1:0]    busy_regs;

  ooo_issue_unit #(.QDEPTH(QD), .ENQ_W(EW), .WB_PORTS(WP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .enq_vld(enq_vld), .enq_cls(enq_cls), .enq_dst(enq_dst),
    .enq_src1(enq_src1), .enq_src2(enq_src2),
    .fu_full(fu_full), .wb_vld(wb_vld), .wb_reg(wb_reg),
    .iss_vld(iss_vld), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .q_remove(q_remove), .q_count(q_count), .busy_regs(busy_regs)
  );

  typedef struct { int cls; int dst; int s1; int s2; } ins_t;
  ins_t  mq[$];
  bit    pend[NR];
  int    n_vec = 0, n_bad = 0;
  string phase = "reset";
  bit    auto_wb = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): got %0d expected %0d", req, phase, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic put(int l, int c, int d, int a, int b);
    enq_vld[l]            = 1'b1;
    enq_cls[2*l +: 2]     = 2'(c);
    enq_dst[RW*l +: RW]   = RW'(d);
    enq_src1[RW*l +: RW]  = RW'(a);
    enq_src2[RW*l +: RW]  = RW'(b);
  endtask

  task automatic wb(int p, int r);
    wb_vld[p]          = 1'b1;
    wb_reg[RW*p +: RW] = RW'(r);
  endtask

  // choose writebacks among registers the model holds pending
  task automatic pick_wb();
    bit used[NR];
    for (int p = 0; p < WP; p++) begin
      if ($urandom_range(0, 9) < 4) begin
        int cand[$];
        for (int r = 1; r < NR; r++) if (pend[r] && !used[r]) cand.push_back(r);
        if (cand.size() > 0) begin
          int r = cand[$urandom_range(0, cand.size() - 1)];
          used[r] = 1'b1;
          wb(p, r);
        end
      end
    end
  endtask

  // reference: decide issue from model state, compare, then advance
  task automatic model_step();
    bit   wr_a[NR];
    bit   rd_a[NR];
    bit   taken[3];
    int   exp_v[3], exp_d[3], exp_a[3], exp_b[3];
    bit   gone[QD];
    ins_t keep[$];
    int   room;
    logic [NR-1:0] exp_busy;
    for (int r = 0; r < NR; r++) exp_busy[r] = pend[r];
    chk("R10 queue occupancy", int'(q_count), mq.size());
    chk("R8 pending bits", int'(busy_regs == exp_busy), 1);
    for (int f = 0; f < 3; f++) exp_v[f] = 0;
    for (int k = 0; k < mq.size(); k++) begin
      ins_t e = mq[k];
      bit ok = !fu_full[e.cls] && !taken[e.cls];
      if (e.s1 != 0 && (pend[e.s1] || wr_a[e.s1])) ok = 0;
      if (e.s2 != 0 && (pend[e.s2] || wr_a[e.s2])) ok = 0;
      if (e.dst != 0 && (pend[e.dst] || wr_a[e.dst] || rd_a[e.dst])) ok = 0;
      if (ok) begin
        taken[e.cls] = 1; gone[k] = 1;
        exp_v[e.cls] = 1; exp_d[e.cls] = e.dst; exp_a[e.cls] = e.s1; exp_b[e.cls] = e.s2;
      end
      if (e.dst != 0) wr_a[e.dst] = 1;
      rd_a[e.s1] = 1; rd_a[e.s2] = 1;
    end
    for (int f = 0; f < 3; f++) begin
      chk("R2 issue strobe", int'(iss_vld[f]), exp_v[f]);
      if (exp_v[f] == 1 && iss_vld[f]) begin
        chk("R12 issued dst", int'(iss_dst[RW*f +: RW]), exp_d[f]);
        chk("R12 issued src1", int'(iss_src1[RW*f +: RW]), exp_a[f]);
        chk("R12 issued src2", int'(iss_src2[RW*f +: RW]), exp_b[f]);
      end
    end
    for (int k = 0; k < QD; k++) chk("R3 removed slot", int'(q_remove[k]), int'(gone[k]));
    room = QD - mq.size();
    for (int k = 0; k < mq.size(); k++) begin
      if (gone[k]) begin
        if (mq[k].dst != 0) pend[mq[k].dst] = 1;
      end else keep.push_back(mq[k]);
    end
    for (int p = 0; p < WP; p++) if (wb_vld[p]) pend[int'(wb_reg[RW*p +: RW])] = 0;
    pend[0] = 0;
    for (int l = 0; l < EW; l++) begin
      if (enq_vld[l] && room > 0) begin
        ins_t n;
        n.cls = int'(enq_cls[2*l +: 2]);
        n.dst = int'(enq_dst[RW*l +: RW]);
        n.s1  = int'(enq_src1[RW*l +: RW]);
        n.s2  = int'(enq_src2[RW*l +: RW]);
        keep.push_back(n);
        room--;
      end
    end
    mq = keep;
  endtask

  task automatic cyc();
    if (auto_wb) pick_wb();
    @(negedge clk);
    model_step();
    @(posedge clk);
    #1ns;
    enq_vld = '0;
    wb_vld  = '0;
  endtask

  initial begin
    #2000000ns;
    n_bad++;
    $display("FAIL watchdog: run did not end in time");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 empty after reset", int'(q_count), 0);
    chk("R1 no pending after reset", int'(busy_regs == '0), 1);
    chk("R1 no issue after reset", int'(iss_vld), 0);
    @(posedge clk); #1ns;
    rst_n = 1'b1;

    phase = "R9 register 0 stays free";
    put(0, 0, 0, 0, 0); put(1, 1, 0, 0, 0);
    cyc(); cyc(); cyc();

    phase = "R6 source from older queued producer";
    put(0, 1, 1, 2, 3); put(1, 2, 4, 1, 5);
    cyc(); cyc();
    phase = "R5 writeback cycle still blocks reader";
    wb(0, 1); cyc();
    cyc();
    wb(0, 4); cyc();

    phase = "R4 full unit holds its class";
    fu_full = 3'b010;
    put(0, 1, 6, 0, 0); put(1, 2, 9, 0, 0);
    cyc(); cyc(); cyc();
    fu_full = 3'b000;
    cyc();
    wb(0, 6); wb(1, 9); cyc();

    phase = "R7 read and write ordering";
    put(0, 2, 7, 8, 0); put(1, 1, 8, 0, 0);
    cyc(); cyc(); cyc();
    put(0, 0, 7, 0, 0);
    cyc(); cyc();
    wb(0, 7); wb(1, 8); cyc();
    cyc();
    wb(0, 7); cyc();

    phase = "R3 oldest ready entry first";
    put(0, 0, 9, 0, 0); put(1, 0, 10, 0, 0);
    cyc(); cyc(); cyc();
    wb(0, 9); wb(1, 10); cyc();

    phase = "R11 enqueue limited by free slots";
    fu_full = 3'b111;
    put(0, 1, 11, 0, 0); put(1, 0, 12, 0, 0); cyc();
    put(0, 2, 13, 0, 0); put(1, 1, 14, 0, 0); cyc();
    put(0, 0, 15, 0, 0); put(1, 2, 16, 0, 0); cyc();

    phase = "R10 compaction keeps order";
    fu_full = 3'b001;
    put(0, 2, 17, 0, 0); put(1, 1, 18, 0, 0); cyc();
    put(0, 2, 19, 0, 0); cyc();
    cyc();
    fu_full = 3'b000;
    cyc(); cyc();

    phase = "R2 R5 R6 R7 R8 random mix";
    auto_wb = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      for (int l = 0; l < EW; l++)
        if ($urandom_range(0, 1) == 1)
          put(l, $urandom_range(0, 2), $urandom_range(0, 7),
              $urandom_range(0, 7), $urandom_range(0, 7));
      for (int f = 0; f < 3; f++) fu_full[f] = ($urandom_range(0, 4) == 0);
      cyc();
    end
    fu_full = 3'b000;
    for (int c = 0; c < 40; c++) cyc();

    report();
    $finish;
  end
endmodule